// File: doc/BRIEF.md
# Vacuum fluorescent display scan controller

This block refreshes a multiplexed vacuum fluorescent display without software help. The frame is split into equal digit periods. In each period one grid line is active and the segment lines carry that digit's pattern. The pattern comes from a small display memory, which the block reads through a one-cycle-latency read port. Software only writes the memory and sets the configuration inputs. The controller then cycles through the digits, gates the outputs for brightness, and moves on to the next digit.

Three settings can be programmed: the number of segment lines, the number of digits and one of eight brightness levels. Brightness is set by blanking the start of every digit period. One extra period after the last digit is kept for keyboard scanning. In that period every output is dark, and a single-clock interrupt marks its start. There is also a second grid mode. In this mode each period's grid pattern is taken from the upper bits of that digit's memory record, instead of from the fixed one-hot order.

Top module: `fluo_scan`

## Requirements
- R1: While rstN is low, and after its release until the first digit period begins (7 clocks later), segOut and gridOut are all zero and keyIrq is low.
- R2: Digit d's 40-bit record is the memory bytes at addresses d*5+k for k=0..4, with byte k on segment bits 8k+7..8k. memData is taken one clock after memRd is high. After reset the first reads go to addresses 0,1,2,3,4 on consecutive clocks. memAddr stays below 80 whenever memRd is high.
- R3: The segment count is cfgSegCount clamped to 9..40. Segment bits at or above the count are always zero.
- R4: The digit count D is cfgDigCount clamped to 2..16. Digit periods run d=0,1,..,D-1 in that order, each driving gridOut bit d alone. The first period after reset is digit 0.
- R5: After digit D-1 comes one key-scan period in which segOut and gridOut are zero. keyIrq is high for exactly the first clock of that period. The next frame then starts at digit 0.
- R6: Every period lasts 64 ticks. A tick is a clock edge with tickEn high. While tickEn is low, the outputs hold their values.
- R7: At level L = cfgLevel (0..7), both outputs are zero for the first (8-L)*4 ticks of every period. Level 7 is the brightest.
- R8: With cfgFreeGrid=1, gridOut equals record bits 39..24 with bits at or above D cleared, and the segment count is limited to at most 24.
- R9: All configuration inputs are sampled only on entry to digit 0, so a change takes effect at the next frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| tickEn | input | 1 | Base tick enable |
| cfgSegCount | input | 6 | Requested segment count |
| cfgDigCount | input | 5 | Requested digit count |
| cfgLevel | input | 3 | Brightness level, 7 brightest |
| cfgFreeGrid | input | 1 | Grid pattern taken from the record |
| memRd | output | 1 | Display memory read strobe |
| memAddr | output | 7 | Display memory byte address |
| memData | input | 8 | Read data, one clock after memRd |
| segOut | output | 40 | Segment lines |
| gridOut | output | 16 | Digit (grid) lines |
| keyIrq | output | 1 | Key-scan interrupt pulse |

## Verification
The assertions check on every cycle the properties that need no frame history. These are: a one-hot grid outside the record-driven mode, segment bits beyond the latched count, dark outputs in the blanking window, before start-up and at the key interrupt, a one-clock interrupt, a read address in range, and outputs that hold while tickEn is low. The bench compares every sampled cycle with a model of its own that tracks period, tick and the frame-latched configuration. It does this for random and edge configurations, tick-enable gaps and mid-frame configuration changes. Only these scenarios can show the digit order, the record-to-segment byte mapping, the exact blanking length and the deferral of configuration to the next frame.

// File: rtl/fluo_scan_pkg.sv
package fluo_scan_pkg;
  localparam int SEG_MAX      = 40;
  localparam int SEG_MIN      = 9;
  localparam int DIG_MAX      = 16;
  localparam int DIG_MIN      = 2;
  localparam int PERIOD_TICKS = 64;
  localparam int LEVELS       = 8;
  localparam int BYTE_BITS    = 8;
  localparam int REC_BYTES    = SEG_MAX / BYTE_BITS;
  localparam int MEM_BYTES    = DIG_MAX * REC_BYTES;
  localparam int FREE_SEG_MAX = SEG_MAX - DIG_MAX;
  localparam int BLANK_STEP   = PERIOD_TICKS / (2 * LEVELS);
  localparam int SEG_W        = $clog2(SEG_MAX + 1);
  localparam int DIG_W        = $clog2(DIG_MAX + 1);
  localparam int SLOT_W       = $clog2(DIG_MAX);
  localparam int TICK_W       = $clog2(PERIOD_TICKS);
  localparam int LVL_W        = $clog2(LEVELS);
  localparam int ADDR_W       = $clog2(MEM_BYTES + REC_BYTES);
  localparam int BSEL_W       = $clog2(REC_BYTES);

  typedef struct packed {
    logic              commit;
    logic              capValid;
    logic [BSEL_W-1:0] capByte;
  } scanStrobe_t;
endpackage

// File: rtl/fluo_scan_ctrl.sv
module fluo_scan_ctrl
  import fluo_scan_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              tickEn,
  input  logic [SEG_W-1:0]  cfgSegCount,
  input  logic [DIG_W-1:0]  cfgDigCount,
  input  logic [LVL_W-1:0]  cfgLevel,
  input  logic              cfgFreeGrid,
  output logic              memRd,
  output logic [ADDR_W-1:0] memAddr,
  output scanStrobe_t       strobe,
  output logic              started,
  output logic              inKey,
  output logic              lit,
  output logic [SLOT_W-1:0] slot,
  output logic [SEG_W-1:0]  segLim,
  output logic [DIG_W-1:0]  digLim,
  output logic              freeL,
  output logic              keyIrq
);
  localparam int BL_W = TICK_W + 1;

  logic [TICK_W-1:0] tickCnt;
  logic [LVL_W-1:0]  levelL;
  logic              fetchBusy;
  logic [BSEL_W-1:0] fetchCnt;
  logic              shadowFull;
  logic              capValid;
  logic [BSEL_W-1:0] capByte;
  logic              lastDigit;
  logic              commit;
  logic [DIG_W-1:0]  nextIdx;
  logic [SEG_W-1:0]  segClamp;
  logic [SEG_W-1:0]  segEff;
  logic [DIG_W-1:0]  digClamp;
  logic [BL_W-1:0]   blankTicks;

  always_comb begin
    lastDigit = !inKey && ({1'b0, slot} == DIG_W'(digLim - 1'b1));
    nextIdx   = inKey ? '0 : ({1'b0, slot} + 1'b1);
    memRd     = fetchBusy && !lastDigit;
    memAddr   = ADDR_W'(int'(nextIdx) * REC_BYTES + int'(fetchCnt));
    commit    = started ? (tickEn && tickCnt == TICK_W'(PERIOD_TICKS - 1)) : shadowFull;

    if (cfgSegCount < SEG_W'(SEG_MIN))      segClamp = SEG_W'(SEG_MIN);
    else if (cfgSegCount > SEG_W'(SEG_MAX)) segClamp = SEG_W'(SEG_MAX);
    else                                    segClamp = cfgSegCount;
    segEff = (cfgFreeGrid && segClamp > SEG_W'(FREE_SEG_MAX)) ? SEG_W'(FREE_SEG_MAX) : segClamp;

    if (cfgDigCount < DIG_W'(DIG_MIN))      digClamp = DIG_W'(DIG_MIN);
    else if (cfgDigCount > DIG_W'(DIG_MAX)) digClamp = DIG_W'(DIG_MAX);
    else                                    digClamp = cfgDigCount;

    blankTicks = BL_W'((LEVELS - int'(levelL)) * BLANK_STEP);
    lit        = started && ({1'b0, tickCnt} >= blankTicks);

    strobe.commit   = commit;
    strobe.capValid = capValid;
    strobe.capByte  = capByte;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      started    <= 1'b0;
      inKey      <= 1'b1;
      slot       <= '0;
      tickCnt    <= '0;
      segLim     <= SEG_W'(SEG_MAX);
      digLim     <= DIG_W'(DIG_MAX);
      levelL     <= '0;
      freeL      <= 1'b0;
      fetchBusy  <= 1'b1;
      fetchCnt   <= '0;
      shadowFull <= 1'b0;
      capValid   <= 1'b0;
      capByte    <= '0;
      keyIrq     <= 1'b0;
    end else begin
      capValid <= memRd;
      capByte  <= fetchCnt;
      keyIrq   <= commit && started && lastDigit;
      if (commit) begin
        started    <= 1'b1;
        tickCnt    <= '0;
        fetchBusy  <= 1'b1;
        fetchCnt   <= '0;
        shadowFull <= 1'b0;
        if (inKey) begin
          inKey  <= 1'b0;
          slot   <= '0;
          segLim <= segEff;
          digLim <= digClamp;
          levelL <= cfgLevel;
          freeL  <= cfgFreeGrid;
        end else if (lastDigit) begin
          inKey <= 1'b1;
        end else begin
          slot <= slot + 1'b1;
        end
      end else begin
        if (started && tickEn) tickCnt <= tickCnt + 1'b1;
        if (fetchBusy) begin
          if (lastDigit || fetchCnt == BSEL_W'(REC_BYTES - 1)) fetchBusy <= 1'b0;
          else fetchCnt <= fetchCnt + 1'b1;
          if (lastDigit) shadowFull <= 1'b1;
        end
        if (capValid && capByte == BSEL_W'(REC_BYTES - 1)) shadowFull <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/fluo_scan_dp.sv
module fluo_scan_dp
  import fluo_scan_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  scanStrobe_t          strobe,
  input  logic [BYTE_BITS-1:0] memData,
  input  logic                 lit,
  input  logic                 inKey,
  input  logic [SLOT_W-1:0]    slot,
  input  logic [SEG_W-1:0]     segLim,
  input  logic [DIG_W-1:0]     digLim,
  input  logic                 freeL,
  output logic [SEG_MAX-1:0]   segOut,
  output logic [DIG_MAX-1:0]   gridOut
);
  logic [SEG_MAX-1:0] shadowRec;
  logic [SEG_MAX-1:0] activeRec;
  logic [SEG_MAX-1:0] segMask;
  logic [DIG_MAX-1:0] gridMask;
  logic [DIG_MAX-1:0] oneHot;
  logic [DIG_MAX-1:0] freeGrid;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shadowRec <= '0;
      activeRec <= '0;
    end else begin
      for (int b = 0; b < REC_BYTES; b++) begin
        if (strobe.capValid && strobe.capByte == BSEL_W'(b))
          shadowRec[b*BYTE_BITS +: BYTE_BITS] <= memData;
      end
      if (strobe.commit) activeRec <= shadowRec;
    end
  end

  for (genvar i = 0; i < SEG_MAX; i++) begin : g_segMask
    assign segMask[i] = (SEG_W'(i) < segLim);
  end

  for (genvar d = 0; d < DIG_MAX; d++) begin : g_grid
    assign gridMask[d] = (DIG_W'(d) < digLim);
    assign oneHot[d]   = (slot == SLOT_W'(d));
  end

  always_comb begin
    freeGrid = activeRec[SEG_MAX-1 -: DIG_MAX] & gridMask;
    segOut   = (lit && !inKey) ? (activeRec & segMask) : '0;
    gridOut  = (lit && !inKey) ? (freeL ? freeGrid : oneHot) : '0;
  end
endmodule

// File: rtl/fluo_scan.sv
module fluo_scan
  import fluo_scan_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 tickEn,
  input  logic [SEG_W-1:0]     cfgSegCount,
  input  logic [DIG_W-1:0]     cfgDigCount,
  input  logic [LVL_W-1:0]     cfgLevel,
  input  logic                 cfgFreeGrid,
  output logic                 memRd,
  output logic [ADDR_W-1:0]    memAddr,
  input  logic [BYTE_BITS-1:0] memData,
  output logic [SEG_MAX-1:0]   segOut,
  output logic [DIG_MAX-1:0]   gridOut,
  output logic                 keyIrq
);
  scanStrobe_t       strobe;
  logic              started;
  logic              inKey;
  logic              lit;
  logic [SLOT_W-1:0] slot;
  logic [SEG_W-1:0]  segLim;
  logic [DIG_W-1:0]  digLim;
  logic              freeL;

  fluo_scan_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .tickEn(tickEn),
    .cfgSegCount(cfgSegCount), .cfgDigCount(cfgDigCount),
    .cfgLevel(cfgLevel), .cfgFreeGrid(cfgFreeGrid),
    .memRd(memRd), .memAddr(memAddr), .strobe(strobe),
    .started(started), .inKey(inKey), .lit(lit), .slot(slot),
    .segLim(segLim), .digLim(digLim), .freeL(freeL), .keyIrq(keyIrq)
  );

  fluo_scan_dp u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .memData(memData),
    .lit(lit), .inKey(inKey), .slot(slot), .segLim(segLim),
    .digLim(digLim), .freeL(freeL), .segOut(segOut), .gridOut(gridOut)
  );
endmodule

// File: rtl/fluo_scan_chk.sv
module fluo_scan_chk
  import fluo_scan_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              tickEn,
  input logic              memRd,
  input logic [ADDR_W-1:0] memAddr,
  input logic [SEG_MAX-1:0] segOut,
  input logic [DIG_MAX-1:0] gridOut,
  input logic              keyIrq,
  input logic              started,
  input logic              lit,
  input logic              freeL,
  input logic [SEG_W-1:0]  segLim
);
  // R1
  idle_dark_chk: assert property (@(posedge clk) disable iff (!rstN)
    !started |-> (segOut == '0 && gridOut == '0 && !keyIrq));

  // R2
  addr_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    memRd |-> (int'(memAddr) < MEM_BYTES));

  // R3
  seg_limit_chk: assert property (@(posedge clk) disable iff (!rstN)
    (segOut >> segLim) == '0);

  // R4
  grid_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    !freeL |-> $onehot0(gridOut));

  // R5
  key_dark_chk: assert property (@(posedge clk) disable iff (!rstN)
    keyIrq |-> (gridOut == '0 && segOut == '0));

  // R5
  key_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    keyIrq |=> !keyIrq);

  // R6
  tick_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (started && !tickEn) |=> ($stable(gridOut) && $stable(segOut)));

  // R7
  blank_dark_chk: assert property (@(posedge clk) disable iff (!rstN)
    !lit |-> (gridOut == '0 && segOut == '0));
endmodule

bind fluo_scan fluo_scan_chk u_chk (
  .clk(clk), .rstN(rstN), .tickEn(tickEn), .memRd(memRd), .memAddr(memAddr),
  .segOut(segOut), .gridOut(gridOut), .keyIrq(keyIrq), .started(started),
  .lit(lit), .freeL(freeL), .segLim(segLim)
);

// File: tb/fluo_scan_bench.sv
module fluo_scan_bench;
  import fluo_scan_pkg::*;

  localparam int CLK_PERIOD = 10;

  logic                 clk = 1'b0;
  logic                 rstN;
  logic                 tickEn;
  logic [SEG_W-1:0]     cfgSegCount;
  logic [DIG_W-1:0]     cfgDigCount;
  logic [LVL_W-1:0]     cfgLevel;
  logic                 cfgFreeGrid;
  logic                 memRd;
  logic [ADDR_W-1:0]    memAddr;
  logic [BYTE_BITS-1:0] memData = '0;
  logic [SEG_MAX-1:0]   segOut;
  logic [DIG_MAX-1:0]   gridOut;
  logic                 keyIrq;
  logic [7:0]           mem [MEM_BYTES];

  int total = 0;
  int bad = 0;
  bit mKey, mFirst, mPending, mFree;
  int mSlot, mTick, mSegL, mDigL, mLvl, nDone;
  string ctx = "base";

  fluo_scan u_fluo_scan (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .cfgSegCount(cfgSegCount),
    .cfgDigCount(cfgDigCount), .cfgLevel(cfgLevel), .cfgFreeGrid(cfgFreeGrid),
    .memRd(memRd), .memAddr(memAddr), .memData(memData),
    .segOut(segOut), .gridOut(gridOut), .keyIrq(keyIrq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk)
    if (memRd) memData <= (int'(memAddr) < MEM_BYTES) ? mem[memAddr] : 8'h00;

  function automatic int clampI(int v, int lo, int hi);
    return (v < lo) ? lo : (v > hi) ? hi : v;
  endfunction

  function automatic logic [SEG_MAX-1:0] recOf(int s);
    logic [SEG_MAX-1:0] r;
    for (int b = 0; b < REC_BYTES; b++) r[b*8 +: 8] = mem[s*REC_BYTES + b];
    return r;
  endfunction

  function automatic bit inBlank();
    return mTick < (LEVELS - mLvl) * BLANK_STEP;
  endfunction

  function automatic logic [SEG_MAX-1:0] expSeg();
    int lim;
    logic [SEG_MAX:0] mask;
    if (mKey || inBlank()) return '0;
    lim  = mFree ? ((mSegL > FREE_SEG_MAX) ? FREE_SEG_MAX : mSegL) : mSegL;
    mask = ({{SEG_MAX{1'b0}}, 1'b1} << lim) - 1'b1;
    return recOf(mSlot) & mask[SEG_MAX-1:0];
  endfunction

  function automatic logic [DIG_MAX-1:0] expGrid();
    logic [DIG_MAX:0] mask;
    logic [SEG_MAX-1:0] r;
    if (mKey || inBlank()) return '0;
    if (!mFree) return DIG_MAX'(1) << mSlot;
    mask = ({{DIG_MAX{1'b0}}, 1'b1} << mDigL) - 1'b1;
    r = recOf(mSlot);
    return r[SEG_MAX-1 -: DIG_MAX] & mask[DIG_MAX-1:0];
  endfunction

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h slot=%0d tick=%0d key=%0d", tag, act, exp, mSlot, mTick, mKey);
    end
  endtask

  task automatic commitModel();
    if (mKey) begin
      mKey     = 1'b0;
      mSlot    = 0;
      mSegL    = clampI(int'(cfgSegCount), SEG_MIN, SEG_MAX);
      mDigL    = clampI(int'(cfgDigCount), DIG_MIN, DIG_MAX);
      mLvl     = int'(cfgLevel);
      mFree    = cfgFreeGrid;
      mPending = 1'b0;
    end else if (mSlot == mDigL - 1) begin
      mKey = 1'b1;
    end else begin
      mSlot++;
    end
  endtask

  // Called at a falling edge: compare, drive tickEn, advance model, move to next falling edge.
  task automatic stepCycle(bit te);
    string gTag, sTag;
    gTag = mPending ? "R9" : mKey ? "R5" : inBlank() ? "R7" : mFree ? "R8" : "R4";
    sTag = mPending ? "R9" : mKey ? "R5" : inBlank() ? "R7" : mFree ? "R8" : "R2,R3";
    check({gTag, "/", ctx, " grid"}, 64'(gridOut), 64'(expGrid()));
    check({sTag, "/", ctx, " seg"}, 64'(segOut), 64'(expSeg()));
    check({"R5/", ctx, " keyIrq"}, 64'(keyIrq), 64'(mKey && mFirst));
    tickEn = te;
    if (te) begin
      if (mTick == PERIOD_TICKS - 1) begin
        mTick = 0;
        commitModel();
        mFirst = 1'b1;
        nDone++;
      end else begin
        mTick++;
        mFirst = 1'b0;
      end
    end else begin
      mFirst = 1'b0;
    end
    @(negedge clk);
  endtask

  task automatic syncKey();
    int n = 0;
    tickEn = 1'b1;
    @(negedge clk);
    while (!keyIrq && n < 5000) begin
      @(negedge clk);
      n++;
    end
    if (n >= 5000) check("R5 key-scan interrupt missing", 64'(0), 64'(1));
    mKey = 1'b1; mTick = 0; mFirst = 1'b1; mPending = 1'b0;
  endtask

  task automatic runPeriods(int n, int pct);
    nDone = 0;
    while (nDone < n) stepCycle(($urandom % 100) < pct);
  endtask

  task automatic fillMem();
    for (int a = 0; a < MEM_BYTES; a++) mem[a] = 8'($urandom);
  endtask

  task automatic setCfg(int s, int d, int l, bit f);
    cfgSegCount = SEG_W'(s);
    cfgDigCount = DIG_W'(d);
    cfgLevel    = LVL_W'(l);
    cfgFreeGrid = f;
  endtask

  task automatic scenario(string name, int s, int d, int l, bit f, int pct);
    ctx = name;
    fillMem();
    setCfg(s, d, l, f);
    syncKey();
    runPeriods(clampI(d, DIG_MIN, DIG_MAX) + 2, pct);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    rstN = 1'b0;
    tickEn = 1'b1;
    setCfg(20, 4, 7, 1'b0);
    fillMem();
    repeat (5) @(negedge clk);
    // R1: dark during reset
    check("R1 seg in reset", 64'(segOut), 64'(0));
    check("R1 grid in reset", 64'(gridOut), 64'(0));
    check("R1 keyIrq in reset", 64'(keyIrq), 64'(0));
    rstN = 1'b1;
    for (int k = 0; k < 10; k++) begin
      if (k < 5) begin
        // R2: start-up reads 0..4 on consecutive clocks
        check("R2 start-up memRd", 64'(memRd), 64'(1));
        check("R2 start-up memAddr", 64'(memAddr), 64'(k));
      end else if (k == 5) begin
        check("R2 start-up read stops", 64'(memRd), 64'(0));
      end
      if (k < 7) begin
        check("R1 dark before first period", 64'({segOut, gridOut, keyIrq}), 64'(0));
      end
      @(negedge clk);
    end
    repeat (10) @(negedge clk);
    // R4: digit 0 lit first (period began 7 clocks after release; tick 13 now)
    mKey = 1'b0; mSlot = 0; mTick = 13; mSegL = 20; mDigL = 4; mLvl = 7; mFree = 1'b0;
    check("R4 first period is digit 0", 64'(gridOut), 64'(1));
    check("R2 first record on segments", 64'(segOut), 64'(expSeg()));

    // Boundary configurations
    scenario("R3 R4 R7 min counts dimmest", 9, 2, 0, 1'b0, 100);
    scenario("R3 R4 R7 max counts brightest", 40, 16, 7, 1'b0, 100);
    scenario("R3 R4 clamp low", 3, 1, 4, 1'b0, 100);
    scenario("R3 R4 clamp high", 63, 31, 2, 1'b0, 100);
    scenario("R8 free grid", 40, 5, 5, 1'b1, 100);
    scenario("R8 free grid short", 12, 16, 6, 1'b1, 100);

    // Random configurations and tick patterns
    for (int it = 0; it < 6; it++) begin
      scenario("random", int'($urandom % 64), int'($urandom % 32), int'($urandom % 8),
               1'($urandom), (it % 2 == 0) ? 100 : 70);
    end

    // R6: stall with tickEn low, then irregular ticks
    ctx = "R6 stall";
    fillMem();
    setCfg(30, 3, 6, 1'b0);
    syncKey();
    runPeriods(1, 100);
    for (int c = 0; c < 20; c++) stepCycle(1'b1);
    for (int c = 0; c < 200; c++) stepCycle(1'b0);
    runPeriods(4, 40);

    // R9: configuration changed mid-frame waits for the next frame
    ctx = "R9 mid-frame change";
    fillMem();
    setCfg(33, 6, 7, 1'b0);
    syncKey();
    runPeriods(3, 100);
    for (int c = 0; c < 10; c++) stepCycle(1'b1);
    setCfg(15, 3, 1, 1'b1);
    mPending = 1'b1;
    runPeriods(12, 100);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule